// File: doc/BRIEF.md
# Pin Bank with Alternate-Function Multiplexer

This block is one bank of thirty-two general-purpose pins with a small word-addressed register port. Software changes the output latch and the direction of any subset of pins through separate set and clear strobe registers. No read-modify-write is needed, so two agents that touch different pins cannot interfere with each other. Each pin also has a two-bit function select, held as one bit in each of two independent select registers. It hands the pad either to the GPIO core or to one of three on-chip peripheral functions.

Pad drivers appear as output-enable, output-value, pull-enable and pull-polarity signals. The pull polarity is not stored on its own: it comes from the pin's output latch bit. A per-pin keep bit decides what happens while the chip-level sleep request is high. Either the pin holds its normal configuration, or it is forced to a pulled input. Pad levels are resynchronised through two flops before software or the peripherals see them.

Top module: `pin_bank`

## Requirements
- R1: The bank has NPINS (default 32) pins, and bit n of every register, every pad vector and every peripheral vector belongs to pin n.
- R2: A write to the latch-set register (word address 1) sets each latch bit whose data bit is 1. A write to the latch-clear register (address 2) clears those bits. Bits written as 0 keep their value, and reading either address returns the latch.
- R3: A write to the direction-set register (address 3) makes the pins whose data bit is 1 outputs. A write to the direction-clear register (address 4) makes them inputs, other bits are untouched, and reading either address returns the direction (1 = output).
- R4: Select register A (address 5) and select register B (address 6) are plain read/write registers. For each pin the pair {A bit, B bit} picks the pad source: 00 GPIO (output-enable = direction, value = latch), 10 function A, 01 function B, 11 function C. A peripheral source drives both output-enable and value.
- R5: Pull-off register (address 7) is read/write. A 1 turns the pin's pull off, a 0 turns it on, and the pull polarity always equals the latch bit (1 = up), so changing the latch changes both pull direction and the driven value.
- R6: Keep register (address 8) is read/write. While sleep_req is 1, a pin whose keep bit is 0 has output-enable 0, output value 0 and its pull turned on, and a pin whose keep bit is 1 behaves as in normal operation. The normal drive returns in the same cycle that sleep_req falls.
- R7: Reading address 0 returns every pad level, inputs and outputs alike, after two clock edges of synchronisation. The same synchronised vector drives pin_in.
- R8: After reset every pin is a GPIO input: latch, direction, both selects and keep are 0, and the pull-off bits are 0, so all pulls are on and pulled down.
- R9: Writes to address 0 or to any unmapped address (9 to 15) change no register and no pad output, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address for read and write |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for bus_addr (combinational) |
| sleep_req | input | 1 | Chip sleep request |
| pad_in | input | NPINS | Raw pad levels |
| pin_in | output | NPINS | Synchronised pad levels for peripherals |
| alt_a_oe | input | NPINS | Function A output enable |
| alt_a_out | input | NPINS | Function A output value |
| alt_b_oe | input | NPINS | Function B output enable |
| alt_b_out | input | NPINS | Function B output value |
| alt_c_oe | input | NPINS | Function C output enable |
| alt_c_out | input | NPINS | Function C output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_out | output | NPINS | Pad output value |
| pad_pull_en | output | NPINS | Pad pull resistor enable |
| pad_pull_up | output | NPINS | Pad pull polarity (1 = up) |

## Verification
The hardest case to reach is a bank where all four mux sources, both directions, both pull settings and both keep values are mixed across pins at once, while sleep is toggling. Only then does a pin-indexing or priority slip show up. The stimulus loads independent pseudo-random patterns into both select registers, the latch, the direction, the pull-off and the keep register, along with the peripheral vectors. The expected pad vectors are rebuilt bit by bit from the requirement rules, with sleep low, then high, then low again. The two-edge synchroniser delay is pinned down by reading the level register one and two edges after a pad change.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_LEVEL    = 4'd0,
        REG_OUT_SET  = 4'd1,
        REG_OUT_CLR  = 4'd2,
        REG_DIR_SET  = 4'd3,
        REG_DIR_CLR  = 4'd4,
        REG_SEL_A    = 4'd5,
        REG_SEL_B    = 4'd6,
        REG_PULL_OFF = 4'd7,
        REG_KEEP     = 4'd8
    } reg_addr_e;

    // Encoding is {select A bit, select B bit}
    typedef enum logic [1:0] {
        SRC_GPIO = 2'b00,
        SRC_FB   = 2'b01,
        SRC_FA   = 2'b10,
        SRC_FC   = 2'b11
    } pad_src_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic pull_en;
        logic pull_up;
    } pad_drive_t;

    function automatic pad_src_e pick_src(input logic a_bit, input logic b_bit);
        return pad_src_e'({a_bit, b_bit});
    endfunction

endpackage

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
    import pin_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NPINS-1:0]    wdata,
    input  logic [NPINS-1:0]    level,
    output logic [NPINS-1:0]    rdata,
    output logic [NPINS-1:0]    latch,
    output logic [NPINS-1:0]    dir,
    output logic [NPINS-1:0]    sel_a,
    output logic [NPINS-1:0]    sel_b,
    output logic [NPINS-1:0]    pull_off,
    output logic [NPINS-1:0]    keep
);

    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch    <= '0;
            dir      <= '0;
            sel_a    <= '0;
            sel_b    <= '0;
            pull_off <= '0;
            keep     <= '0;
        end else if (we) begin
            case (sel)
                REG_OUT_SET:  latch    <= latch | wdata;
                REG_OUT_CLR:  latch    <= latch & ~wdata;
                REG_DIR_SET:  dir      <= dir | wdata;
                REG_DIR_CLR:  dir      <= dir & ~wdata;
                REG_SEL_A:    sel_a    <= wdata;
                REG_SEL_B:    sel_b    <= wdata;
                REG_PULL_OFF: pull_off <= wdata;
                REG_KEEP:     keep     <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            REG_LEVEL:                rdata = level;
            REG_OUT_SET, REG_OUT_CLR: rdata = latch;
            REG_DIR_SET, REG_DIR_CLR: rdata = dir;
            REG_SEL_A:                rdata = sel_a;
            REG_SEL_B:                rdata = sel_b;
            REG_PULL_OFF:             rdata = pull_off;
            REG_KEEP:                 rdata = keep;
            default:                  rdata = '0;
        endcase
    end

    assert_latch_set_R2: assert property (@(posedge clk) disable iff (rst)
        (we && sel == REG_OUT_SET) |=>
            ((latch & $past(wdata)) == $past(wdata)) &&
            ((latch & ~$past(wdata)) == ($past(latch) & ~$past(wdata))));

    assert_latch_clr_R2: assert property (@(posedge clk) disable iff (rst)
        (we && sel == REG_OUT_CLR) |=>
            ((latch & $past(wdata)) == '0) &&
            ((latch & ~$past(wdata)) == ($past(latch) & ~$past(wdata))));

    assert_dir_set_R3: assert property (@(posedge clk) disable iff (rst)
        (we && sel == REG_DIR_SET) |=>
            ((dir & $past(wdata)) == $past(wdata)) &&
            ((dir & ~$past(wdata)) == ($past(dir) & ~$past(wdata))));

    assert_dir_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (we && sel == REG_DIR_CLR) |=>
            ((dir & $past(wdata)) == '0) &&
            ((dir & ~$past(wdata)) == ($past(dir) & ~$past(wdata))));

    assert_level_write_inert_R9: assert property (@(posedge clk) disable iff (rst)
        (we && (sel == REG_LEVEL || addr > 4'd8)) |=>
            $stable(latch) && $stable(dir) && $stable(sel_a) &&
            $stable(sel_b) && $stable(pull_off) && $stable(keep));

endmodule

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] raw,
    output logic [NPINS-1:0] synced
);

    logic [STAGES-1:0][NPINS-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= raw;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign synced = chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            logic [1:0] warm;
            always_ff @(posedge clk) begin
                if (rst)              warm <= '0;
                else if (warm != 2'd3) warm <= warm + 2'd1;
            end
            assert_two_edge_delay_R7: assert property (@(posedge clk) disable iff (rst)
                (warm >= 2'd2) |-> (synced == $past(raw, 2)));
        end
    endgenerate

endmodule

// File: rtl/pin_bank_mux.sv
module pin_bank_mux
    import pin_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] latch,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] sel_a,
    input  logic [NPINS-1:0] sel_b,
    input  logic [NPINS-1:0] pull_off,
    input  logic [NPINS-1:0] keep,
    input  logic             sleep,
    input  logic [NPINS-1:0] fa_oe,
    input  logic [NPINS-1:0] fa_out,
    input  logic [NPINS-1:0] fb_oe,
    input  logic [NPINS-1:0] fb_out,
    input  logic [NPINS-1:0] fc_oe,
    input  logic [NPINS-1:0] fc_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pull_en,
    output logic [NPINS-1:0] pad_pull_up
);

    genvar n;
    generate
        for (n = 0; n < NPINS; n++) begin : g_pin
            pad_drive_t awake, final_drv;
            pad_src_e   src;

            assign src = pick_src(sel_a[n], sel_b[n]);

            always_comb begin
                awake.pull_en = ~pull_off[n];
                awake.pull_up = latch[n];
                case (src)
                    SRC_FA:  begin awake.oe = fa_oe[n]; awake.out = fa_out[n]; end
                    SRC_FB:  begin awake.oe = fb_oe[n]; awake.out = fb_out[n]; end
                    SRC_FC:  begin awake.oe = fc_oe[n]; awake.out = fc_out[n]; end
                    default: begin awake.oe = dir[n];   awake.out = latch[n];  end
                endcase
            end

            always_comb begin
                if (sleep && !keep[n]) begin
                    final_drv.oe      = 1'b0;
                    final_drv.out     = 1'b0;
                    final_drv.pull_en = 1'b1;
                    final_drv.pull_up = latch[n];
                end else begin
                    final_drv = awake;
                end
            end

            assign pad_oe[n]      = final_drv.oe;
            assign pad_out[n]     = final_drv.out;
            assign pad_pull_en[n] = final_drv.pull_en;
            assign pad_pull_up[n] = final_drv.pull_up;
        end
    endgenerate

endmodule

// File: rtl/pin_bank.sv
module pin_bank
    import pin_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NPINS-1:0]   bus_wdata,
    output logic [NPINS-1:0]   bus_rdata,
    input  logic               sleep_req,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pin_in,
    input  logic [NPINS-1:0]   alt_a_oe,
    input  logic [NPINS-1:0]   alt_a_out,
    input  logic [NPINS-1:0]   alt_b_oe,
    input  logic [NPINS-1:0]   alt_b_out,
    input  logic [NPINS-1:0]   alt_c_oe,
    input  logic [NPINS-1:0]   alt_c_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_pull_en,
    output logic [NPINS-1:0]   pad_pull_up
);

    logic [NPINS-1:0] latch, dir, sel_a, sel_b, pull_off, keep;

    pin_bank_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pad_in),
        .synced (pin_in)
    );

    pin_bank_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .level    (pin_in),
        .rdata    (bus_rdata),
        .latch    (latch),
        .dir      (dir),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .pull_off (pull_off),
        .keep     (keep)
    );

    pin_bank_mux #(.NPINS(NPINS)) u_mux (
        .latch       (latch),
        .dir         (dir),
        .sel_a       (sel_a),
        .sel_b       (sel_b),
        .pull_off    (pull_off),
        .keep        (keep),
        .sleep       (sleep_req),
        .fa_oe       (alt_a_oe),
        .fa_out      (alt_a_out),
        .fb_oe       (alt_b_oe),
        .fb_out      (alt_b_out),
        .fc_oe       (alt_c_oe),
        .fc_out      (alt_c_out),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .pad_pull_en (pad_pull_en),
        .pad_pull_up (pad_pull_up)
    );

    assert_sleep_releases_R6: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> (((pad_oe | pad_out) & ~keep) == '0) && ((pad_pull_en | keep) == '1));

    assert_gpio_source_R4: assert property (@(posedge clk) disable iff (rst)
        !sleep_req |-> ((pad_oe & ~(sel_a | sel_b)) == (dir & ~(sel_a | sel_b))));

endmodule

// File: tb/sim_pin_bank.sv
module sim_pin_bank;

    localparam int N = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic sleep_req = 1'b0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pin_in;
    logic [N-1:0] a_oe = '0, a_out = '0, b_oe = '0, b_out = '0, c_oe = '0, c_out = '0;
    logic [N-1:0] pad_oe, pad_out, pad_pull_en, pad_pull_up;

    int checks = 0;
    int failures = 0;

    logic [N-1:0] m_latch, m_dir, m_a, m_b, m_poff, m_keep;

    always #10 clk = ~clk;

    pin_bank u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
        .pad_in(pad_in), .pin_in(pin_in),
        .alt_a_oe(a_oe), .alt_a_out(a_out), .alt_b_oe(b_oe), .alt_b_out(b_out),
        .alt_c_oe(c_oe), .alt_c_out(c_out),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic load_all();
        wr(4'd1, m_latch);  wr(4'd2, ~m_latch);
        wr(4'd3, m_dir);    wr(4'd4, ~m_dir);
        wr(4'd5, m_a);      wr(4'd6, m_b);
        wr(4'd7, m_poff);   wr(4'd8, m_keep);
    endtask

    task automatic chk_pads(input string req);
        logic [N-1:0] e_oe, e_out, e_pe, e_pu;
        for (int i = 0; i < N; i++) begin
            case ({m_a[i], m_b[i]})
                2'b10:   begin e_oe[i] = a_oe[i]; e_out[i] = a_out[i]; end
                2'b01:   begin e_oe[i] = b_oe[i]; e_out[i] = b_out[i]; end
                2'b11:   begin e_oe[i] = c_oe[i]; e_out[i] = c_out[i]; end
                default: begin e_oe[i] = m_dir[i]; e_out[i] = m_latch[i]; end
            endcase
            e_pe[i] = ~m_poff[i];
            e_pu[i] = m_latch[i];
            if (sleep_req && !m_keep[i]) begin
                e_oe[i] = 1'b0; e_out[i] = 1'b0; e_pe[i] = 1'b1;
            end
        end
        #1;
        chk({req, " oe"}, pad_oe, e_oe);
        chk({req, " out"}, pad_out, e_out);
        chk({req, " pull_en"}, pad_pull_en, e_pe);
        chk({req, " pull_up"}, pad_pull_up, e_pu);
    endtask

    task automatic chk_regs(input string req);
        logic [N-1:0] v;
        rd(4'd1, v); chk({req, " latch"}, v, m_latch);
        rd(4'd2, v); chk({req, " latch alias"}, v, m_latch);
        rd(4'd3, v); chk({req, " dir"}, v, m_dir);
        rd(4'd4, v); chk({req, " dir alias"}, v, m_dir);
        rd(4'd5, v); chk({req, " sel_a"}, v, m_a);
        rd(4'd6, v); chk({req, " sel_b"}, v, m_b);
        rd(4'd7, v); chk({req, " pull_off"}, v, m_poff);
        rd(4'd8, v); chk({req, " keep"}, v, m_keep);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] v, pat;
        m_latch = '0; m_dir = '0; m_a = '0; m_b = '0; m_poff = '0; m_keep = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R8 reset state
        chk_regs("R8 reset");
        rd(4'd0, v); chk("R8 reset level", v, '0);
        chk_pads("R8 reset pads");

        // R2 walking latch set/clear; R1 bit n is pin n
        for (int n = 0; n < N; n++) begin
            wr(4'd1, 32'h1 << n);
            rd(4'd1, v); chk("R2 set walk R1", v, 32'h1 << n);
            wr(4'd1, 32'h0);
            rd(4'd2, v); chk("R2 zero-set keeps", v, 32'h1 << n);
            wr(4'd2, 32'h1 << n);
            rd(4'd1, v); chk("R2 clr walk", v, '0);
        end
        wr(4'd1, 32'hA5A5_0F0F); wr(4'd2, 32'h0000_FFFF);
        rd(4'd1, v); chk("R2 partial clear", v, 32'hA5A5_0000);
        wr(4'd2, '1);

        // R3 walking direction
        for (int n = 0; n < N; n++) begin
            wr(4'd3, 32'h1 << n);
            rd(4'd3, v); chk("R3 dir set walk", v, 32'h1 << n);
            m_dir = 32'h1 << n;
            chk_pads("R3 gpio oe R1");
            wr(4'd4, 32'h1 << n);
            rd(4'd4, v); chk("R3 dir clr walk", v, '0);
        end
        m_dir = '0;

        // R4 / R5 mixed sweeps
        for (int k = 0; k < 12; k++) begin
            m_latch = $urandom; m_dir = $urandom; m_a = $urandom; m_b = $urandom;
            m_poff = $urandom; m_keep = '0;
            a_oe = $urandom; a_out = $urandom; b_oe = $urandom; b_out = $urandom;
            c_oe = $urandom; c_out = $urandom;
            load_all();
            chk_regs("R4 R5 regs");
            chk_pads("R4 R5 mux");
        end

        // R5 pull polarity tracks latch change on the fly
        wr(4'd5, '0); m_a = '0; wr(4'd6, '0); m_b = '0;
        wr(4'd7, 32'h0000_FFFF); m_poff = 32'h0000_FFFF;
        wr(4'd3, '1); m_dir = '1;
        wr(4'd1, 32'h00FF_00FF); m_latch = m_latch | 32'h00FF_00FF;
        chk_pads("R5 pull up via latch");
        wr(4'd2, 32'h0F0F_0F0F); m_latch = m_latch & ~32'h0F0F_0F0F;
        chk_pads("R5 pull down via latch");

        // R6 sleep
        for (int k = 0; k < 6; k++) begin
            m_latch = $urandom; m_dir = $urandom; m_a = $urandom; m_b = $urandom;
            m_poff = $urandom; m_keep = $urandom;
            a_oe = $urandom; a_out = $urandom; b_oe = $urandom; b_out = $urandom;
            c_oe = $urandom; c_out = $urandom;
            load_all();
            @(negedge clk); sleep_req = 1'b1;
            chk_pads("R6 sleep");
            @(negedge clk); sleep_req = 1'b0;
            chk_pads("R6 wake same cycle");
        end

        // R7 synchroniser: two edges, independent of direction
        wr(4'd3, 32'hFFFF_0000); m_dir = (m_dir | 32'hFFFF_0000);
        for (int k = 0; k < 6; k++) begin
            logic [N-1:0] old;
            old = pin_in;
            pat = $urandom;
            @(negedge clk); pad_in = pat;
            @(negedge clk);
            rd(4'd0, v); chk("R7 one edge still old", v, old);
            @(negedge clk);
            rd(4'd0, v); chk("R7 level after two edges", v, pat);
            #1; chk("R7 pin_in", pin_in, pat);
        end

        // R9 writes to level and unmapped addresses
        wr(4'd0, '1);
        chk_regs("R9 level write");
        chk_pads("R9 level write pads");
        for (int a = 9; a < 16; a++) begin
            wr(a[3:0], '1);
            rd(a[3:0], v); chk("R9 unmapped reads 0", v, '0);
        end
        chk_regs("R9 unmapped write");
        chk_pads("R9 unmapped pads");

        // R8 reset again returns defaults
        @(negedge clk); rst = 1'b1; pad_in = '0;
        repeat (3) @(negedge clk); rst = 1'b0;
        m_latch = '0; m_dir = '0; m_a = '0; m_b = '0; m_poff = '0; m_keep = '0;
        #1;
        chk_regs("R8 re-reset");
        chk_pads("R8 re-reset pads");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule